// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block produces the horizontal and vertical timing of an NTSC-style raster. It counts pixel clocks into lines and lines into fields. It outputs a one-cycle line strobe, a one-cycle field strobe, the current line number within the field, and a composite sync bit. The field length is selectable. Interlaced scanning gives 262.5 lines per field, which is a 525-line frame with the second field starting in the middle of a line. Non-interlaced scanning gives 263 lines per field.

Two configuration bits choose the timing source. With internal sync, the counters free-run. With external sync, rising edges on the external horizontal and vertical sync inputs realign the line and field counters. External sync takes effect only while the display-enable bit is clear.

A separate checker watches the external horizontal sync input. It measures the spacing of its rising edges against the nominal line period, and it raises a valid flag once a programmable number of consecutive well-spaced pulses have been seen.

Top module: `raster_sync_gen`

## Requirements
- R1: Reset (rst_n low) clears every configuration register: sync source external, interlaced, display bit off, detection code 0000. While reset is held, line_stb, field_stb, csync and hs_valid are 0 and line_num is 0. The first cycle after release is position 0 of line 0.
- R2: Unless an external pulse intervenes, the horizontal position advances by one per clock and wraps after LINE_CLKS clocks. line_stb is 1 for exactly the one cycle at position 0, and line_num advances on each wrap.
- R3: With cfg_progressive = 0 (interlaced), the frame has 525 lines and field_stb fires twice per frame: once at frame line 0, position 0, and once at frame line 262, position LINE_CLKS/2. line_num is the frame line for frame lines 0..262 and the frame line minus 262 for frame lines 263..524.
- R4: With cfg_progressive = 1 (non-interlaced), every field has 263 lines (line_num 0..262), and field_stb fires only at line 0, position 0.
- R5: csync is 1 during the first HS_WIDTH clocks of each line and 0 otherwise. On field lines VS_FIRST through VS_FIRST+VS_LINES-1 the polarity is inverted.
- R6: cfg_int_sync = 1 selects internal sync and 0 selects external sync. External sync is effective only while cfg_disp_on = 0. When it is not effective, ext_hs and ext_vs do not move the line or field counters.
- R7: With external sync effective, a rising edge of ext_hs restarts the line: on the next cycle line_stb is 1 and line_num has advanced by one.
- R8: With external sync effective, a rising edge of ext_vs restarts the field: on the next cycle field_stb is 1 for one cycle and line_num is 0. In this mode field_stb fires only on those edges.
- R9: cfg_det_code is one-hot. 0001, 0010, 0100 and 1000 require 16, 32, 64 and 128 detections. 0000, or any code that is not one-hot, disables checking and holds hs_valid at 0.
- R10: A detection is an ext_hs rising edge that follows the previous rising edge by LINE_CLKS-TOL to LINE_CLKS+TOL clocks, inclusive. The first edge after reset only serves as a reference. An edge outside the window clears the count, and that edge becomes the new reference. hs_valid is 1 once the count reaches the required number.
- R11: If no ext_hs rising edge arrives within LINE_CLKS+TOL clocks of the last one, the count clears. hs_valid is still 1 LINE_CLKS+TOL cycles after the last edge and is 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the four configuration fields below |
| cfg_int_sync | input | 1 | 1 internal sync, 0 external sync |
| cfg_progressive | input | 1 | 1 non-interlaced 263 lines, 0 interlaced 262.5 lines |
| cfg_disp_on | input | 1 | Display enabled; blocks external sync when 1 |
| cfg_det_code | input | 4 | One-hot detection count code |
| ext_hs | input | 1 | External horizontal sync, active high |
| ext_vs | input | 1 | External vertical sync, active high |
| line_stb | output | 1 | One-cycle pulse at the start of each line |
| field_stb | output | 1 | One-cycle pulse at the start of each field |
| line_num | output | 9 | Line number within the field |
| csync | output | 1 | Composite sync, active high |
| hs_valid | output | 1 | External horizontal sync judged present |

## Verification
The raster outputs are decoded directly from the counter registers. The bench therefore predicts them from the number of clock edges since reset release and compares every cycle of two interlaced frames and two non-interlaced fields, in internal mode, at the falling edge.

An external sync edge or a configuration write presented before edge k becomes visible after edge k. The bench samples the realigned line or field one half-cycle after that edge, and the unchanged counters in the ignored cases at the same point.

hs_valid changes one cycle after the qualifying ext_hs edge. The bench checks it after every pulse for all four codes, and it checks the missing-pulse clear at exactly LINE_CLKS+TOL and LINE_CLKS+TOL+1 cycles after the last edge.

// File: rtl/raster_sync_gen.sv
module raster_sync_gen #(
  parameter int LINE_CLKS = 64,
  parameter int HS_WIDTH  = 6,
  parameter int TOL       = 2,
  parameter int VS_FIRST  = 3,
  parameter int VS_LINES  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_int_sync,
  input  logic       cfg_progressive,
  input  logic       cfg_disp_on,
  input  logic [3:0] cfg_det_code,
  input  logic       ext_hs,
  input  logic       ext_vs,
  output logic       line_stb,
  output logic       field_stb,
  output logic [8:0] line_num,
  output logic       csync,
  output logic       hs_valid
);
  localparam int HW   = $clog2(LINE_CLKS);
  localparam int PMAX = LINE_CLKS + TOL + 1;
  localparam int PW   = $clog2(PMAX + 1);
  localparam logic [HW-1:0] H_LAST  = HW'(LINE_CLKS - 1);
  localparam logic [HW-1:0] H_HALF  = HW'(LINE_CLKS / 2);
  localparam logic [HW-1:0] H_SYNC  = HW'(HS_WIDTH);
  localparam logic [PW-1:0] P_MAX   = PW'(PMAX);
  localparam logic [PW-1:0] P_LO    = PW'(LINE_CLKS - TOL);
  localparam logic [PW-1:0] P_HI    = PW'(LINE_CLKS + TOL);
  localparam logic [8:0]    VS_LO   = 9'(VS_FIRST);
  localparam logic [8:0]    VS_HI   = 9'(VS_FIRST + VS_LINES);

  logic          int_q, prog_q, disp_q;
  logic [3:0]    det_q;
  logic [HW-1:0] hcnt;
  logic [9:0]    fl;
  logic          hs_d, vs_d, fstb_q;
  logic [PW-1:0] pcnt;
  logic [7:0]    good;
  logic [7:0]    need;

  logic ext_eff, hs_rise, vs_rise, hs_take, vs_take, line_adv, in_win, field_int;
  logic [9:0] fl_last, fl_next;

  assign ext_eff  = !int_q && !disp_q;
  assign hs_rise  = ext_hs && !hs_d;
  assign vs_rise  = ext_vs && !vs_d;
  assign hs_take  = ext_eff && hs_rise;
  assign vs_take  = ext_eff && vs_rise;
  assign line_adv = (hcnt == H_LAST) || hs_take;
  assign fl_last  = prog_q ? 10'd262 : 10'd524;
  assign fl_next  = (fl >= fl_last) ? 10'd0 : fl + 10'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= 1'b0;
      prog_q <= 1'b0;
      disp_q <= 1'b0;
      det_q  <= 4'b0000;
    end else if (cfg_we) begin
      int_q  <= cfg_int_sync;
      prog_q <= cfg_progressive;
      disp_q <= cfg_disp_on;
      det_q  <= cfg_det_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt   <= '0;
      fl     <= '0;
      hs_d   <= 1'b0;
      vs_d   <= 1'b0;
      fstb_q <= 1'b0;
    end else begin
      hs_d   <= ext_hs;
      vs_d   <= ext_vs;
      hcnt   <= line_adv ? '0 : hcnt + 1'b1;
      fstb_q <= vs_take;
      if (vs_take)       fl <= '0;
      else if (line_adv) fl <= fl_next;
    end
  end

  assign line_num  = (fl >= 10'd263) ? 9'(fl - 10'd262) : fl[8:0];
  assign field_int = (hcnt == '0 && fl == 10'd0) ||
                     (!prog_q && fl == 10'd262 && hcnt == H_HALF);
  assign line_stb  = rst_n && (hcnt == '0);
  assign field_stb = rst_n && (ext_eff ? fstb_q : field_int);
  assign csync     = rst_n && ((hcnt < H_SYNC) ^ (line_num >= VS_LO && line_num < VS_HI));

  assign in_win = (pcnt >= P_LO) && (pcnt <= P_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= P_MAX;
      good <= '0;
    end else if (hs_rise) begin
      pcnt <= PW'(1);
      if (!in_win)             good <= '0;
      else if (good != 8'd128) good <= good + 8'd1;
    end else if (pcnt != P_MAX) begin
      pcnt <= pcnt + 1'b1;
    end else begin
      good <= '0;
    end
  end

  always_comb begin
    case (det_q)
      4'b0001: need = 8'd16;
      4'b0010: need = 8'd32;
      4'b0100: need = 8'd64;
      4'b1000: need = 8'd128;
      default: need = 8'd0;
    endcase
  end

  assign hs_valid = (need != 8'd0) && (good >= need);
endmodule

// File: rtl/raster_sync_gen_chk.sv
module raster_sync_gen_chk #(
  parameter int LINE_CLKS = 64
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         line_stb,
  input logic                         field_stb,
  input logic [8:0]                   line_num,
  input logic                         hs_valid,
  input logic [3:0]                   det,
  input logic                         ext_eff,
  input logic [$clog2(LINE_CLKS)-1:0] hcnt
);
  localparam int HW = $clog2(LINE_CLKS);

  a_r2_position_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_eff && hcnt != HW'(LINE_CLKS - 1)) |=> hcnt == HW'($past(hcnt) + 1'b1));

  a_r2_line_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_eff && line_stb) |=> !line_stb);

  a_r3_line_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    line_num <= 9'd262);

  a_r3_field_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    field_stb |-> (line_num == 9'd0 || line_num == 9'd262));

  a_r8_ext_field_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_eff && field_stb) |-> line_num == 9'd0);

  a_r9_valid_needs_code: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> ($onehot0(det) && det != 4'b0000));
endmodule

bind raster_sync_gen raster_sync_gen_chk #(.LINE_CLKS(LINE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .field_stb(field_stb),
  .line_num(line_num), .hs_valid(hs_valid), .det(det_q), .ext_eff(ext_eff),
  .hcnt(hcnt)
);

// File: tb/raster_sync_gen_tb.sv
module raster_sync_gen_tb;
  localparam int L   = 64;
  localparam int HSW = 6;
  localparam int TOL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_int_sync = 1'b0, cfg_progressive = 1'b0, cfg_disp_on = 1'b0;
  logic [3:0] cfg_det_code = 4'b0000;
  logic ext_hs = 1'b0, ext_vs = 1'b0;
  logic line_stb, field_stb, csync, hs_valid;
  logic [8:0] line_num;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  raster_sync_gen #(.LINE_CLKS(L), .HS_WIDTH(HSW), .TOL(TOL), .VS_FIRST(3), .VS_LINES(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_int_sync(cfg_int_sync),
    .cfg_progressive(cfg_progressive), .cfg_disp_on(cfg_disp_on),
    .cfg_det_code(cfg_det_code), .ext_hs(ext_hs), .ext_vs(ext_vs),
    .line_stb(line_stb), .field_stb(field_stb), .line_num(line_num),
    .csync(csync), .hs_valid(hs_valid)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ext_hs = 1'b0;
    ext_vs = 1'b0;
    cfg_we = 1'b0;
    tick();
    chk("R1 line_stb in reset", int'(line_stb), 0);
    chk("R1 field_stb in reset", int'(field_stb), 0);
    chk("R1 csync in reset", int'(csync), 0);
    chk("R1 hs_valid in reset", int'(hs_valid), 0);
    chk("R1 line_num in reset", int'(line_num), 0);
    rst_n = 1'b1;
  endtask

  task automatic set_cfg(input logic i, input logic p, input logic d, input logic [3:0] c);
    cfg_we = 1'b1;
    cfg_int_sync = i;
    cfg_progressive = p;
    cfg_disp_on = d;
    cfg_det_code = c;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic hs_pulse();
    ext_hs = 1'b1;
    tick();
    ext_hs = 1'b0;
  endtask

  task automatic sweep(input logic prog, input int frames);
    int total;
    do_reset();
    set_cfg(1'b1, prog, 1'b0, 4'b0000);
    total = frames * L * (prog ? 263 : 525);
    for (int n = 1; n < total; n++) begin
      int h, f, ln, ef, ec;
      h  = n % L;
      f  = (n / L) % (prog ? 263 : 525);
      ln = (f >= 263) ? f - 262 : f;
      ef = ((h == 0 && f == 0) || (!prog && f == 262 && h == L / 2)) ? 1 : 0;
      ec = ((h < HSW) ? 1 : 0) ^ ((ln >= 3 && ln < 6) ? 1 : 0);
      chk("R2 line_stb", int'(line_stb), (h == 0) ? 1 : 0);
      chk("R2 line_num", int'(line_num), ln);
      chk(prog ? "R4 field_stb" : "R3 field_stb", int'(field_stb), ef);
      chk("R5 csync", int'(csync), ec);
      tick();
    end
  endtask

  task automatic det_run(input logic [3:0] code, input int need, input int pulses, input string req);
    do_reset();
    set_cfg(1'b0, 1'b0, 1'b0, code);
    for (int i = 0; i <= pulses; i++) begin
      hs_pulse();
      chk(req, int'(hs_valid), (need > 0 && i >= need) ? 1 : 0);
      if (i != pulses) repeat (L - 1) tick();
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1, R6, R7, R8: defaults after reset give external sync
    do_reset();
    repeat (10) tick();
    hs_pulse();
    chk("R7 line_stb after ext_hs", int'(line_stb), 1);
    chk("R7 line_num after ext_hs", int'(line_num), 1);
    repeat (4) tick();
    ext_vs = 1'b1;
    tick();
    chk("R8 field_stb after ext_vs", int'(field_stb), 1);
    chk("R8 line_num after ext_vs", int'(line_num), 0);
    ext_vs = 1'b0;
    tick();
    chk("R8 field_stb one cycle", int'(field_stb), 0);
    set_cfg(1'b0, 1'b0, 1'b1, 4'b0000);
    hs_pulse();
    chk("R6 display on ignores ext_hs", int'(line_stb), 0);
    chk("R6 display on keeps line", int'(line_num), 0);
    ext_vs = 1'b1;
    tick();
    ext_vs = 1'b0;
    chk("R6 display on ignores ext_vs", int'(field_stb), 0);
    set_cfg(1'b1, 1'b0, 1'b0, 4'b0000);
    hs_pulse();
    chk("R6 internal ignores ext_hs", int'(line_stb), 0);

    // R2..R5 exhaustive raster sweeps
    sweep(1'b0, 2);
    sweep(1'b1, 2);

    // R9, R10 every code
    det_run(4'b0001, 16, 17, "R9 code 0001");
    det_run(4'b0010, 32, 33, "R9 code 0010");
    det_run(4'b0100, 64, 65, "R9 code 0100");
    det_run(4'b1000, 128, 129, "R9 code 1000");
    det_run(4'b0000, 0, 20, "R9 code 0000 disabled");
    det_run(4'b0011, 0, 20, "R9 code 0011 disabled");

    // R11 missing pulse after valid
    det_run(4'b0001, 16, 16, "R10 reach 16");
    repeat (L + TOL) tick();
    chk("R11 valid held at window edge", int'(hs_valid), 1);
    tick();
    chk("R11 cleared after missing pulse", int'(hs_valid), 0);

    // R10 window boundaries and early pulse
    do_reset();
    set_cfg(1'b0, 1'b0, 1'b0, 4'b0001);
    hs_pulse();
    for (int i = 1; i <= 16; i++) begin
      repeat (((i % 2) ? L - TOL : L + TOL) - 1) tick();
      hs_pulse();
    end
    chk("R10 boundary periods accepted", int'(hs_valid), 1);
    repeat (L - TOL - 2) tick();
    hs_pulse();
    chk("R10 early pulse clears", int'(hs_valid), 0);
    for (int i = 1; i <= 16; i++) begin
      repeat (L - 1) tick();
      hs_pulse();
    end
    chk("R10 early pulse was new reference", int'(hs_valid), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule